// File: doc/BRIEF.md
# Grouped-Step Instruction Fetch Sequencer

This block is the fetch and operand-fetch controller of a small accumulator machine. It owns four registers (program counter, address register, buffer register, instruction register) plus an operand register. It drives a single-port memory of 1024 words of 16 bits. The memory returns the word at the registered address during the step that follows the address load. Because the program counter is released as soon as its value sits in the address register, its increment shares a step with the instruction read. An instruction is therefore in hand after three steps instead of four.

Once the instruction register is loaded, the two top bits of the word select how the operand is obtained. An immediate instruction takes its low ten bits as the operand at once. A direct instruction uses those bits as the address of the operand. An indirect instruction uses them as the address of a pointer, and the pointer gives the operand address. When the instruction and operand are ready, the block raises a one-cycle valid pulse. It then holds still until the execute side reports completion, and only then starts the next fetch.

Top module: `fetch_seq`

## Requirements
- R1: A synchronous active-high reset clears the program counter to 0, keeps `ex_valid` and `mem_rd` low, and leaves the sequencer at the first fetch step, so the word at address 0 is the first fetched.
- R2: The fetch uses three steps. Step one loads the address register from the program counter. Step two reads memory into the buffer register and increments the program counter. Step three moves the buffer register into the instruction register.
- R3: When `ex_valid` is high, `pc_out` equals the address of the fetched instruction plus one, modulo 1024; 1023 wraps to 0.
- R4: Instruction bits [15:14] give the mode: 00 immediate, 01 direct, 10 indirect, and 11 is handled as immediate. Bits [9:0] give the address or immediate value. While `ex_valid` is high, `ir_out` equals the fetched word.
- R5: An immediate-mode instruction raises `ex_valid` 3 clock edges after its first fetch step. `opnd_out` then holds bits [9:0] of the instruction, zero-extended to 16 bits.
- R6: A direct-mode instruction raises `ex_valid` 5 edges after its first fetch step. `opnd_out` then holds the memory word at address [9:0] of the instruction.
- R7: An indirect-mode instruction raises `ex_valid` 7 edges after its first fetch step. `opnd_out` then holds the memory word whose address is bits [9:0] of the word at address [9:0] of the instruction.
- R8: `ex_valid` is high for exactly one cycle. If `ex_done` is sampled high in that cycle, the next fetch begins on the following edge. Otherwise the sequencer waits, with no memory read and a stable program counter, until `ex_done` is sampled high.
- R9: `mem_addr` always shows the address register. `mem_rd` is high only in read steps: once per immediate instruction, twice per direct instruction, and three times per indirect instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 10 | Memory word address (address register) |
| mem_rd | output | 1 | Read strobe, high in read steps |
| mem_rdata | input | 16 | Word at `mem_addr`, valid in the read step |
| ex_valid | output | 1 | One-cycle pulse: instruction and operand ready |
| ex_done | input | 1 | Execute side has finished; allows the next fetch |
| ir_out | output | 16 | Instruction register |
| opnd_out | output | 16 | Operand register |
| pc_out | output | 10 | Program counter |

## Verification
A program of random words runs through the whole 1024-word space and wraps past the top. Each word is an instruction, so all four mode codes appear in roughly equal numbers. Per-instruction step counts and read counts separate the immediate, direct and indirect paths, and the reserved code is seen to take the immediate path. Directed words at the bottom of memory point to the top address, directly and through a pointer, to exercise the ten-bit field at its extremes. A random delay of zero to three cycles before `ex_done` tells the back-to-back restart apart from the waiting state. A reset in the middle of an instruction shows that the fetch restarts cleanly from address 0.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 16;
    localparam int MODE_HI = DATA_W - 1;
    localparam int MODE_LO = DATA_W - 2;
    localparam int PAD_W   = DATA_W - ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        AM_IMM = 2'b00,
        AM_DIR = 2'b01,
        AM_IND = 2'b10,
        AM_RSV = 2'b11
    } amode_e;

    typedef enum logic [3:0] {
        ST_F1, ST_F2, ST_F3,
        ST_D1, ST_D2,
        ST_I1, ST_I2, ST_I3, ST_I4,
        ST_EXEC, ST_WAIT
    } step_e;

    typedef enum logic [1:0] {
        MAR_KEEP, MAR_PC, MAR_IR, MAR_MBR
    } mar_src_e;

    typedef enum logic [1:0] {
        OPR_KEEP, OPR_IMM, OPR_MEM
    } opr_src_e;

    typedef struct packed {
        mar_src_e mar_src;
        logic     mem_rd;
        logic     mbr_ld;
        logic     pc_inc;
        logic     ir_ld;
        opr_src_e opr_src;
    } uop_t;

    localparam uop_t UOP_NOP = '{
        mar_src: MAR_KEEP, mem_rd: 1'b0, mbr_ld: 1'b0,
        pc_inc: 1'b0, ir_ld: 1'b0, opr_src: OPR_KEEP
    };

    function automatic amode_e mode_of(word_t w);
        return amode_e'(w[MODE_HI:MODE_LO]);
    endfunction

    function automatic addr_t field_of(word_t w);
        return w[ADDR_W-1:0];
    endfunction

    function automatic word_t zext(addr_t a);
        return {{PAD_W{1'b0}}, a};
    endfunction

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
    import fetch_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  amode_e mbr_mode,
    input  logic   ex_done,
    output step_e  step,
    output uop_t   uop,
    output logic   ex_valid
);

    step_e nxt;

    always_ff @(posedge clk) begin
        if (rst) step <= ST_F1;
        else     step <= nxt;
    end

    always_comb begin
        nxt = step;
        uop = UOP_NOP;
        case (step)
            ST_F1: begin
                uop.mar_src = MAR_PC;
                nxt = ST_F2;
            end
            ST_F2: begin
                uop.mem_rd = 1'b1;
                uop.mbr_ld = 1'b1;
                uop.pc_inc = 1'b1;
                nxt = ST_F3;
            end
            ST_F3: begin
                uop.ir_ld = 1'b1;
                case (mbr_mode)
                    AM_DIR:  nxt = ST_D1;
                    AM_IND:  nxt = ST_I1;
                    default: begin
                        uop.opr_src = OPR_IMM;
                        nxt = ST_EXEC;
                    end
                endcase
            end
            ST_D1: begin
                uop.mar_src = MAR_IR;
                nxt = ST_D2;
            end
            ST_D2: begin
                uop.mem_rd  = 1'b1;
                uop.opr_src = OPR_MEM;
                nxt = ST_EXEC;
            end
            ST_I1: begin
                uop.mar_src = MAR_IR;
                nxt = ST_I2;
            end
            ST_I2: begin
                uop.mem_rd = 1'b1;
                uop.mbr_ld = 1'b1;
                nxt = ST_I3;
            end
            ST_I3: begin
                uop.mar_src = MAR_MBR;
                nxt = ST_I4;
            end
            ST_I4: begin
                uop.mem_rd  = 1'b1;
                uop.opr_src = OPR_MEM;
                nxt = ST_EXEC;
            end
            ST_EXEC: nxt = ex_done ? ST_F1 : ST_WAIT;
            ST_WAIT: if (ex_done) nxt = ST_F1;
            default: nxt = ST_F1;
        endcase
    end

    assign ex_valid = (step == ST_EXEC);

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ex_valid |=> !ex_valid);

    // R8
    wait_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && !ex_done) |=> (step == ST_WAIT));

endmodule

// File: rtl/fetch_regs.sv
module fetch_regs
    import fetch_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  uop_t  uop,
    input  word_t mem_rdata,
    output addr_t pc,
    output addr_t mar,
    output word_t mbr,
    output word_t ir,
    output word_t opr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
            opr <= '0;
        end else begin
            if (uop.pc_inc) pc <= pc + addr_t'(1);
            case (uop.mar_src)
                MAR_PC:  mar <= pc;
                MAR_IR:  mar <= field_of(ir);
                MAR_MBR: mar <= field_of(mbr);
                default: mar <= mar;
            endcase
            if (uop.mbr_ld) mbr <= mem_rdata;
            if (uop.ir_ld)  ir  <= mbr;
            case (uop.opr_src)
                OPR_IMM: opr <= zext(field_of(mbr));
                OPR_MEM: opr <= mem_rdata;
                default: opr <= opr;
            endcase
        end
    end

    // R2
    mar_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (uop.mar_src == MAR_PC) |=> (mar == $past(pc)));

    // R2
    mbr_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (uop.mem_rd && uop.mbr_ld) |=> (mbr == $past(mem_rdata)));

    // R3
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !uop.pc_inc |=> $stable(pc));

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
    import fetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ex_valid,
    input  logic              ex_done,
    output logic [DATA_W-1:0] ir_out,
    output logic [DATA_W-1:0] opnd_out,
    output logic [ADDR_W-1:0] pc_out
);

    step_e step;
    uop_t  uop;
    addr_t pc, mar;
    word_t mbr, ir, opr;

    fetch_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .mbr_mode (mode_of(mbr)),
        .ex_done  (ex_done),
        .step     (step),
        .uop      (uop),
        .ex_valid (ex_valid)
    );

    fetch_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .uop       (uop),
        .mem_rdata (mem_rdata),
        .pc        (pc),
        .mar       (mar),
        .mbr       (mbr),
        .ir        (ir),
        .opr       (opr)
    );

    assign mem_addr = mar;
    assign mem_rd   = uop.mem_rd;
    assign ir_out   = ir;
    assign opnd_out = opr;
    assign pc_out   = pc;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0 && !ex_valid && step == ST_F1));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && !ex_done) |=> (!mem_rd && $stable(pc_out)));

endmodule

// File: tb/tb_fetch_seq.sv
`timescale 1ns/1ps
module tb_fetch_seq;
    import fetch_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ex_done = 1'b0;
    logic [9:0]  mem_addr;
    logic        mem_rd;
    logic [15:0] mem_rdata;
    logic        ex_valid;
    logic [15:0] ir_out;
    logic [15:0] opnd_out;
    logic [9:0]  pc_out;

    logic [15:0] mem [0:1023];

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    fetch_seq dut (
        .clk (clk), .rst (rst),
        .mem_addr (mem_addr), .mem_rd (mem_rd), .mem_rdata (mem_rdata),
        .ex_valid (ex_valid), .ex_done (ex_done),
        .ir_out (ir_out), .opnd_out (opnd_out), .pc_out (pc_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int len_of(input logic [15:0] w);
        case (w[15:14])
            2'b01:   return 5;
            2'b10:   return 7;
            default: return 3;
        endcase
    endfunction

    function automatic int reads_of(input logic [15:0] w);
        case (w[15:14])
            2'b01:   return 2;
            2'b10:   return 3;
            default: return 1;
        endcase
    endfunction

    function automatic logic [15:0] opnd_of(input logic [15:0] w);
        logic [15:0] ptr;
        case (w[15:14])
            2'b01: return mem[w[9:0]];
            2'b10: begin
                ptr = mem[w[9:0]];
                return mem[ptr[9:0]];
            end
            default: return {6'b0, w[9:0]};
        endcase
    endfunction

    function automatic string tag_of(input logic [15:0] w);
        case (w[15:14])
            2'b01:   return "R6";
            2'b10:   return "R7";
            default: return "R2 R5";
        endcase
    endfunction

    // starts at a negedge with the sequencer at its first fetch step
    task automatic run_one(input int a, input int gap);
        logic [15:0] w;
        logic [9:0]  pexp;
        int cnt;
        int rd;
        w    = mem[a];
        pexp = 10'(a + 1);
        cnt  = 0;
        rd   = 0;
        do begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (mem_rd) rd++;
        end while (!ex_valid && cnt < 20);
        chk(cnt == len_of(w), tag_of(w), "steps to ex_valid", cnt, len_of(w));
        chk(ir_out == w, "R4", "ir_out", ir_out, w);
        chk(opnd_out == opnd_of(w), tag_of(w), "opnd_out", opnd_out, opnd_of(w));
        chk(pc_out == pexp, "R3", "pc_out", pc_out, pexp);
        chk(rd == reads_of(w), "R9", "read count", rd, reads_of(w));
        for (int g = 0; g < gap; g++) begin
            @(posedge clk);
            @(negedge clk);
            chk(!ex_valid && !mem_rd, "R8", "quiet while waiting",
                {ex_valid, mem_rd}, 0);
            chk(pc_out == pexp, "R8", "pc stable while waiting", pc_out, pexp);
        end
        ex_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ex_done = 1'b0;
        chk(!ex_valid, "R8", "ex_valid single cycle", ex_valid, 0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) mem[i] = 16'($urandom);
        // directed corner words
        mem[0] = {2'b00, 4'h3, 10'h3FF};   // immediate, max field
        mem[1] = {2'b01, 4'h5, 10'h3FF};   // direct to top address
        mem[2] = {2'b10, 4'h9, 10'h000};   // indirect via word 0 -> 0x3FF
        mem[3] = {2'b11, 4'hA, 10'h005};   // reserved code, immediate path

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(pc_out == 10'd0, "R1", "pc_out in reset", pc_out, 0);
        chk(!ex_valid && !mem_rd, "R1", "outputs in reset", {ex_valid, mem_rd}, 0);
        rst = 1'b0;

        for (int i = 0; i < 1030; i++)
            run_one(i % 1024, int'($urandom_range(0, 3)));

        // mid-instruction reset
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(pc_out == 10'd0, "R1", "pc_out after mid reset", pc_out, 0);
        chk(!ex_valid && !mem_rd, "R1", "outputs after mid reset",
            {ex_valid, mem_rd}, 0);
        rst = 1'b0;
        for (int i = 0; i < 8; i++)
            run_one(i, int'($urandom_range(0, 3)));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule